// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation tree from memory. A per-process root register holds the physical byte address of the first-level table. The upper ten address bits select a first-level entry, which points at a second-level table. The next ten bits select a second-level entry, which carries the physical frame number and two status bits. The low twelve bits pass through unchanged as the offset inside a 4 KB page.

A client hands over one address at a time with a valid/ready handshake. The walker issues one-cycle read pulses on a word memory port and waits for each response, whatever its latency. It then gives a single-cycle completion pulse with either the physical address or a fault code. The operating system loads a new root on a process switch through a separate load strobe. A load that lands while a walk is running changes nothing for that walk.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req` and `done` are 0, and the root register holds `BASE_RESET` (default 0).
- R2: The first read of a walk has address root + 4 × vaddr[31:22]. It is issued in the cycle after the request is accepted.
- R3: The second read is issued only after the first response has arrived. Its address is {first entry[31:12], 12'h000} + 4 × vaddr[21:12]. No walk issues more than two reads.
- R4: In an entry, bit 0 means valid, bit 1 means resident, bits [31:12] are the frame or table base, and bits [11:2] are ignored. The walk succeeds when the second-level entry has both bits set. Success gives `done_fault` = 0 and `done_paddr` = {entry[31:12], vaddr[11:0]}.
- R5: A first-level entry with bit 0 clear ends the walk after exactly one read, with `done_fault` = 1 (invalid).
- R6: A second-level entry with bit 0 clear ends the walk with `done_fault` = 1 (invalid).
- R7: A second-level entry that is valid but not resident ends the walk with `done_fault` = 2 (page fault). On any fault, `done_paddr` is 0.
- R8: Only one walk is active at a time. `req_ready` is 0 from acceptance through the `done` cycle. `done` and `mem_req` are one-cycle pulses.
- R9: `ctx_load` writes `ctx_base` into the root register. If the load comes while a walk is busy, or in the cycle a request is accepted, it applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load a new root table base |
| ctx_base | input | 32 | Physical byte address of the new first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, zero on a fault |
| done_fault | output | 2 | 0 none, 1 invalid, 2 page fault |

## Verification
The assertions assume the memory returns exactly one `mem_rvalid` per `mem_req`, never in the same cycle as the request. They also assume no spurious response arrives while the walker is idle. The bench memory model keeps a single pending read and answers it after zero to three extra cycles, rotating the delay on each read. The driver raises `req_valid` only while `req_ready` is high. It changes the root only on cycles it chooses, so that the same-cycle load-and-accept case is not exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int PFN_W     = PA_W - OFF_W;
    localparam int ENT_BYTES = 4;
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);
    localparam int LO_W      = IDX_W + OFF_W;
    localparam int VLD_BIT   = 0;
    localparam int RES_BIT   = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L0_REQ, ST_L0_WAIT, ST_L1_REQ, ST_L1_WAIT, ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PAGE    = 2'd2
    } fault_e;

    typedef struct packed {
        walk_st_e          st;
        logic [PA_W-1:0]   base;
        logic [LO_W-1:0]   va_lo;
        logic [PA_W-1:0]   maddr;
        logic [PA_W-1:0]   paddr;
        fault_e            flt;
    } walk_s;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int TW = 32,
    parameter int IW = 10,
    parameter int SH = 2
) (
    input  logic [TW-1:0] tbase,
    input  logic [IW-1:0] idx,
    output logic [TW-1:0] eaddr
);
    localparam int PAD = TW - IW;
    assign eaddr = tbase + ({{PAD{1'b0}}, idx} << SH);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  ent,
    output logic             vld,
    output logic             res,
    output logic [PFN_W-1:0] pfn
);
    logic unused_rsvd;
    assign vld         = ent[VLD_BIT];
    assign res         = ent[RES_BIT];
    assign pfn         = ent[PA_W-1:OFF_W];
    assign unused_rsvd = ^ent[OFF_W-1:RES_BIT+1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter logic [31:0] BASE_RESET = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctx_load,
    input  logic [31:0] ctx_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] done_paddr,
    output logic [1:0]  done_fault
);
    walk_s d, q;

    logic [PA_W-1:0]  l0_addr, l1_addr;
    logic             ent_vld, ent_res;
    logic [PFN_W-1:0] ent_pfn;

    // first-level entry address from the current root and the incoming index
    ptw_addr_gen #(.TW(PA_W), .IW(IDX_W), .SH(ENT_SHIFT)) u_l0_addr (
        .tbase (q.base),
        .idx   (req_vaddr[VA_W-1 -: IDX_W]),
        .eaddr (l0_addr)
    );

    // second-level entry address from the returned table pointer
    ptw_addr_gen #(.TW(PA_W), .IW(IDX_W), .SH(ENT_SHIFT)) u_l1_addr (
        .tbase ({ent_pfn, {OFF_W{1'b0}}}),
        .idx   (q.va_lo[LO_W-1 -: IDX_W]),
        .eaddr (l1_addr)
    );

    ptw_entry_decode u_dec (
        .ent (mem_rdata),
        .vld (ent_vld),
        .res (ent_res),
        .pfn (ent_pfn)
    );

    always_comb begin
        d = q;
        if (ctx_load) begin
            d.base = ctx_base;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va_lo = req_vaddr[LO_W-1:0];
                    d.maddr = l0_addr;
                    d.st    = ST_L0_REQ;
                end
            end
            ST_L0_REQ: d.st = ST_L0_WAIT;
            ST_L0_WAIT: begin
                if (mem_rvalid) begin
                    if (!ent_vld) begin
                        d.flt   = FLT_INVALID;
                        d.paddr = '0;
                        d.st    = ST_RESP;
                    end else begin
                        d.maddr = l1_addr;
                        d.st    = ST_L1_REQ;
                    end
                end
            end
            ST_L1_REQ: d.st = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rvalid) begin
                    d.st = ST_RESP;
                    if (!ent_vld) begin
                        d.flt   = FLT_INVALID;
                        d.paddr = '0;
                    end else if (!ent_res) begin
                        d.flt   = FLT_PAGE;
                        d.paddr = '0;
                    end else begin
                        d.flt   = FLT_NONE;
                        d.paddr = {ent_pfn, q.va_lo[OFF_W-1:0]};
                    end
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.base  <= BASE_RESET;
            q.va_lo <= '0;
            q.maddr <= '0;
            q.paddr <= '0;
            q.flt   <= FLT_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_req    = (q.st == ST_L0_REQ) || (q.st == ST_L1_REQ);
    assign mem_addr   = q.maddr;
    assign done       = (q.st == ST_RESP);
    assign done_paddr = q.paddr;
    assign done_fault = q.flt;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [11:0] va_off,
    input logic        mem_req,
    input logic        done,
    input logic [31:0] done_paddr,
    input logic [1:0]  done_fault
);
    logic [1:0]  rd_cnt;
    logic [11:0] acc_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            acc_off <= '0;
        end else if (req_valid && req_ready) begin
            rd_cnt  <= '0;
            acc_off <= va_off;
        end else if (mem_req && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 2'd1;
        end
    end

    a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req && !req_ready));

    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r8_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && !mem_req));

    a_r3_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_cnt == 2'd1 || rd_cnt == 2'd2));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == 2'd0) |-> (done_paddr[11:0] == acc_off && rd_cnt == 2'd2));

    a_r5_single_read_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_cnt == 2'd1) |-> (done_fault == 2'd1));

    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault != 2'd0) |-> (done_paddr == 32'h0 && done_fault != 2'd3));
endmodule

bind pt_walker ptw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .va_off     (req_vaddr[11:0]),
    .mem_req    (mem_req),
    .done       (done),
    .done_paddr (done_paddr),
    .done_fault (done_fault)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_load = 1'b0;
    logic [31:0] ctx_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_base(ctx_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .done_paddr(done_paddr),
        .done_fault(done_fault)
    );

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  flt;
        int          nrd;
        logic [31:0] a0;
        logic [31:0] a1;
        string       tag;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        sb_q[$];
    logic [31:0] exp_base = 32'h0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // reference walk built from the requirement text
    function automatic exp_t model(input logic [31:0] base, input logic [31:0] va, input string tag);
        exp_t e;
        logic [31:0] e0, e1;
        e.tag = tag;
        e.a0  = base + {20'h0, va[31:22], 2'b00};
        e.a1  = 32'h0;
        e.nrd = 1;
        e.pa  = 32'h0;
        e0    = rd(e.a0);
        if (!e0[0]) begin
            e.flt = 2'd1;
        end else begin
            e.nrd = 2;
            e.a1  = {e0[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
            e1    = rd(e.a1);
            if (!e1[0])      e.flt = 2'd1;
            else if (!e1[1]) e.flt = 2'd2;
            else begin
                e.flt = 2'd0;
                e.pa  = {e1[31:12], va[11:0]};
            end
        end
        return e;
    endfunction

    // memory responder: one pending read, latency rotates 0..3 extra cycles
    initial begin
        bit          pend = 1'b0;
        int          cnt = 0;
        int          lat = 0;
        logic [31:0] paddr_r = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(paddr_r);
                    pend       = 1'b0;
                end else begin
                    cnt--;
                end
            end
            if (mem_req && rst_n) begin
                pend    = 1'b1;
                paddr_r = mem_addr;
                cnt     = lat;
                lat     = (lat + 1) % 4;
            end
        end
    end

    // monitor: collects read addresses and compares each completion
    initial begin
        logic [31:0] seen [4];
        int          nseen = 0;
        bit          prev_done = 1'b0;
        exp_t        e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) check(!done, "R8", "done longer than one cycle", {31'h0, done}, 32'h0);
                if (mem_req) begin
                    if (nseen < 4) seen[nseen] = mem_addr;
                    nseen++;
                end
                if (done) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected done", 32'h1, 32'h0);
                    end else begin
                        e = sb_q.pop_front();
                        check(done_fault == e.flt, e.tag, "fault code", {30'h0, done_fault}, {30'h0, e.flt});
                        check(done_paddr == e.pa, e.tag, "physical address", done_paddr, e.pa);
                        check(nseen == e.nrd, (e.nrd == 1) ? "R5" : "R3", "read count", nseen, e.nrd);
                        check(nseen >= 1 && seen[0] == e.a0, "R2", "first read address", seen[0], e.a0);
                        if (e.nrd == 2 && nseen >= 2)
                            check(seen[1] == e.a1, "R3", "second read address", seen[1], e.a1);
                        check(!req_ready, "R8", "ready during done", {31'h0, req_ready}, 32'h0);
                    end
                    nseen = 0;
                end
                prev_done = done;
            end
        end
    end

    task automatic do_req(input logic [31:0] va, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        sb_q.push_back(model(exp_base, va, tag));
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8", "ready after accept", {31'h0, req_ready}, 32'h0);
    endtask

    task automatic load_ctx(input logic [31:0] b);
        @(negedge clk);
        ctx_load = 1'b1;
        ctx_base = b;
        exp_base = b;
        @(negedge clk);
        ctx_load = 1'b0;
    endtask

    function automatic logic [31:0] va_of(input int i0, input int i1, input int off);
        return {i0[9:0], i1[9:0], off[11:0]};
    endfunction

    initial begin
        // root at 0 (reset value) and process A root
        mem[32'h0000_0000] = 32'h0002_0001;
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0001_0008] = 32'h0000_0FFC;   // reserved bits set, valid clear
        mem[32'h0002_0014] = 32'h000A_B003;
        mem[32'h0002_0018] = 32'h000C_D001;
        mem[32'h0002_001C] = 32'h0000_0002;
        mem[32'h0002_0020] = 32'h0001_2FFF;   // reserved bits ignored
        mem[32'h0003_0FFC] = 32'hFFFF_F003;
        // process B root
        mem[32'h0004_0004] = 32'h0005_0001;
        mem[32'h0005_0014] = 32'h0007_7003;

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset state", {31'h0, req_ready}, 32'h1);
        check(mem_req == 1'b0, "R1", "mem_req in reset state", {31'h0, mem_req}, 32'h0);
        check(done == 1'b0, "R1", "done in reset state", {31'h0, done}, 32'h0);
        rst_n = 1'b1;

        do_req(va_of(0, 5, 12'h123), "R1");       // reset root
        load_ctx(32'h0001_0000);
        do_req(va_of(1, 5, 12'hABC), "R4");
        do_req(va_of(1, 8, 12'h001), "R4");
        do_req(va_of(1023, 1023, 12'hFFF), "R4");
        do_req(va_of(2, 5, 12'h010), "R5");
        do_req(va_of(3, 0, 12'h000), "R5");
        do_req(va_of(1, 7, 12'h444), "R6");
        do_req(va_of(1, 6, 12'h555), "R7");
        // load during a busy walk: only the next request sees it
        do_req(va_of(1, 5, 12'h0F0), "R9");
        load_ctx(32'h0004_0000);
        do_req(va_of(1, 5, 12'h0F0), "R9");
        do_req(va_of(2, 5, 12'h000), "R9");

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule